// File: doc/BRIEF.md
# Serial Register-Window Transaction Decoder

This block sits behind a serial slave front end that has already turned the wire traffic into bytes. While the transaction-active flag is high, it reads a two-byte header from the received byte stream. The header gives the direction, a 13-bit address and a short length. The block then either serves a burst of one to four register bytes or opens a memory stream. Received bytes are taken through a valid/take handshake. Response bytes leave through a push strobe that waits for the downstream room flag.

The register window, below the memory base, holds a fixed device identifier and a control byte. The control byte drives a one-cycle reset request and a level that enables reception. The window also holds an interrupt mask, sticky interrupt causes, the receive write page, the six-byte station address and a constant link indication. A read whose address is at or above the memory base ignores the length field. It fetches consecutive bytes from a memory read port and pushes them out until the transaction ends. In every read, response bytes are produced as soon as the header is decoded, so they are ready before the host clocks the data phase.

Top module: `swd_window_decoder`

## Requirements
- R1: After reset, irq_n is 1, reset_req and rx_enable are 0, station_addr is zero, and tx_push and mem_req_valid are low.
- R2: Header byte 0 bit 7 selects a write (1) or a read (0), and its bits 6:0 are address bits 12:6. Header byte 1 bits 7:2 are address bits 5:0, and its bits 1:0 are the byte count minus one.
- R3: A register read returns one byte per address, with the address incrementing. Addresses 0x00..0x03 read 0x04, 0x02, 0x02, 0x00, and unmapped register addresses read 0x00.
- R4: Address 0x31 always reads 0x17.
- R5: Addresses 0x20..0x25 hold the station address and read back what was written. The byte at 0x20 appears on station_addr[7:0], and each following byte sits 8 bits higher.
- R6: A write to address 0x00 with bit 0 set raises reset_req for exactly one cycle. Bit 3 of the same write sets the rx_enable level.
- R7: Address 0x16 reads the rx_page input.
- R8: A read at an address at or above 0x100 ignores the count. It requests memory bytes at consecutive addresses starting at the header address and pushes each returned byte, in order, until xact_active falls. After that no further bytes are pushed. A pending request keeps its address until it is accepted.
- R9: tx_push is high only while tx_room is high. Register read bytes are pushed without waiting for any further received bytes.
- R10: A write stores exactly count bytes at consecutive addresses. Further bytes in the same transaction are taken and discarded.
- R11: A pulse on rx_event sets cause bit 0, and a pulse on tx_event sets cause bit 1; the causes read at 0x09 and stay set. Writing 1s to 0x09 clears those bits, and an event in the same cycle wins. The mask is read and written at 0x08. irq_n is low while any cause bit is set together with its mask bit.
- R12: When xact_active falls in mid-transaction, the decoder returns to expecting header byte 0. The next transaction decodes normally.
- R13: rx_take is high only while rx_valid is high. Bytes received during the data phase of a read change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xact_active | input | 1 | Transaction in progress (chip select asserted) |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte is available |
| rx_take | output | 1 | Received byte consumed this cycle |
| tx_byte | output | 8 | Response byte |
| tx_push | output | 1 | Response byte written this cycle |
| tx_room | input | 1 | Response path can accept a byte |
| mem_req_addr | output | 13 | Memory read address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_rsp_data | input | 8 | Memory read data |
| mem_rsp_valid | input | 1 | mem_rsp_data is valid |
| rx_page | input | 8 | Receive write pointer in pages |
| rx_event | input | 1 | Receive event pulse |
| tx_event | input | 1 | Transmit event pulse |
| irq_n | output | 1 | Interrupt, active low |
| reset_req | output | 1 | One-cycle reset request |
| rx_enable | output | 1 | Receive path enable level |
| station_addr | output | 48 | Station address bytes |

## Verification
The bench builds each header with the address split across both bytes. A decoder that swapped the halves or misplaced the count bits would read the wrong register or return the wrong number of bytes. It cuts a four-byte write after one byte and then decodes a fresh transaction; a decoder that kept its old state would take that header as data. It writes more bytes than the count allows and checks the neighbouring register, throttles tx_room and mem_req_ready during a memory stream, and confirms that pushes stop once the transaction ends. Two further cases probe the interrupt logic: a masked cause, which must leave irq_n high, and a clear of one cause while the other stays pending.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int ADDR_W = 13;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] A_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] A_MASK  = 8'h08;
  localparam logic [REG_AW-1:0] A_CAUSE = 8'h09;
  localparam logic [REG_AW-1:0] A_PAGE  = 8'h16;
  localparam logic [REG_AW-1:0] A_STA   = 8'h20;
  localparam logic [REG_AW-1:0] A_LINK  = 8'h31;

  localparam logic [7:0]  LINK_VAL = 8'h17;
  localparam logic [31:0] DEV_ID   = 32'h04020200;
  localparam int CTRL_RST_BIT  = 0;
  localparam int CTRL_RXEN_BIT = 3;

  typedef enum logic [2:0] {
    ST_HDR0, ST_HDR1, ST_WDATA, ST_RREG, ST_MSTR, ST_DRAIN
  } xact_st_t;

  typedef enum logic [1:0] {
    SS_IDLE, SS_REQ, SS_WAIT, SS_PUSH
  } strm_st_t;
endpackage

// File: rtl/swd_irq_ctrl.sv
module swd_irq_ctrl #(
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] ev,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [NC-1:0] wdata,
  output logic [NC-1:0] mask_q,
  output logic [NC-1:0] cause_q,
  output logic          irq_n
);
  logic [NC-1:0] mask_d, cause_d;

  always_comb begin
    mask_d  = mask_we ? wdata : mask_q;
    cause_d = (cause_q & ~(clr_we ? wdata : '0)) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cause_q <= '0;
    end else begin
      mask_q  <= mask_d;
      cause_q <= cause_d;
    end
  end

  assign irq_n = ~|(cause_q & mask_q);

  // R11: an enabled event drives the interrupt low on the next cycle
  p_irq_follows_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ev & mask_q)) && !mask_we) |=> !irq_n);

  // R11: causes are sticky unless a clear write is made
  p_cause_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/swd_reg_bank.sv
module swd_reg_bank
  import swd_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int STA_BYTES = 6,
  parameter int NC        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [REG_AW-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [PAGE_W-1:0]      rx_page,
  input  logic [NC-1:0]          ev,
  output logic                   irq_n,
  output logic                   reset_req,
  output logic                   rx_enable,
  output logic [8*STA_BYTES-1:0] station_addr
);
  logic [STA_BYTES-1:0][7:0] sta_q;
  logic rxen_q, rxen_d, rst_q, rst_d;
  logic ctrl_we, mask_we, clr_we;
  logic [NC-1:0] mask_q, cause_q;

  assign ctrl_we = we && (addr == A_CTRL);
  assign mask_we = we && (addr == A_MASK);
  assign clr_we  = we && (addr == A_CAUSE);

  always_comb begin
    rst_d  = ctrl_we && wdata[CTRL_RST_BIT];
    rxen_d = ctrl_we ? wdata[CTRL_RXEN_BIT] : rxen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      rxen_q <= 1'b0;
    end else begin
      rst_q  <= rst_d;
      rxen_q <= rxen_d;
    end
  end

  for (genvar k = 0; k < STA_BYTES; k++) begin : g_sta
    logic sta_en;
    assign sta_en = we && (addr == REG_AW'(int'(A_STA) + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sta_q[k] <= '0;
      else if (sta_en) sta_q[k] <= wdata;
    end
  end

  swd_irq_ctrl #(.NC(NC)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .mask_we (mask_we),
    .clr_we  (clr_we),
    .wdata   (wdata[NC-1:0]),
    .mask_q  (mask_q),
    .cause_q (cause_q),
    .irq_n   (irq_n)
  );

  always_comb begin
    rdata = 8'h00;
    if (addr < REG_AW'(4))      rdata = DEV_ID[31 - 8*addr[1:0] -: 8];
    else if (addr == A_MASK)    rdata = 8'(mask_q);
    else if (addr == A_CAUSE)   rdata = 8'(cause_q);
    else if (addr == A_PAGE)    rdata = 8'(rx_page);
    else if (addr == A_LINK)    rdata = LINK_VAL;
    for (int k = 0; k < STA_BYTES; k++)
      if (addr == REG_AW'(int'(A_STA) + k)) rdata = sta_q[k];
  end

  assign reset_req    = rst_q;
  assign rx_enable    = rxen_q;
  assign station_addr = sta_q;

  // R6: the reset request never lasts more than one cycle
  p_rst_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
endmodule

// File: rtl/swd_mem_stream.sv
module swd_mem_stream
  import swd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          run,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  input  logic [7:0]    mem_rsp_data,
  input  logic          mem_rsp_valid,
  input  logic          tx_room,
  output logic          tx_push,
  output logic [7:0]    tx_byte
);
  strm_st_t st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0] hold_q, hold_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    hold_d = hold_q;
    if (start) begin
      st_d   = SS_REQ;
      addr_d = start_addr;
    end else if (!run) begin
      st_d = SS_IDLE;
    end else begin
      unique case (st_q)
        SS_REQ:  if (mem_req_ready) begin
                   addr_d = addr_q + 1'b1;
                   st_d   = SS_WAIT;
                 end
        SS_WAIT: if (mem_rsp_valid) begin
                   hold_d = mem_rsp_data;
                   st_d   = SS_PUSH;
                 end
        SS_PUSH: if (tx_room) st_d = SS_REQ;
        default: st_d = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SS_IDLE;
      addr_q <= '0;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      hold_q <= hold_d;
    end
  end

  assign mem_req_valid = (st_q == SS_REQ) && run;
  assign mem_req_addr  = addr_q;
  assign tx_push       = (st_q == SS_PUSH) && run && tx_room;
  assign tx_byte       = hold_q;

  // R8: a stalled request keeps its address while the stream runs
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> ((mem_req_valid && $stable(mem_req_addr)) || !run));
endmodule

// File: rtl/swd_xact_fsm.sv
module swd_xact_fsm
  import swd_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int MEM_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_active,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_take,
  input  logic              tx_room,
  output logic              reg_tx_push,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_we,
  output logic [7:0]        reg_wdata,
  output logic              str_start,
  output logic [AW-1:0]     str_addr,
  output logic              str_run
);
  localparam int HI_W = AW - 6;

  xact_st_t st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [1:0] cnt_q, cnt_d;
  logic wr_q, wr_d;
  logic [AW-1:0] hdr_addr;

  assign hdr_addr = {addr_q[AW-1:6], rx_byte[7:2]};

  always_comb begin
    st_d        = st_q;
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    wr_d        = wr_q;
    rx_take     = 1'b0;
    reg_we      = 1'b0;
    reg_tx_push = 1'b0;
    str_start   = 1'b0;
    if (!xact_active) begin
      st_d = ST_HDR0;
    end else begin
      rx_take = rx_valid;
      unique case (st_q)
        ST_HDR0: if (rx_valid) begin
                   wr_d          = rx_byte[7];
                   addr_d[AW-1:6] = rx_byte[HI_W-1:0];
                   st_d          = ST_HDR1;
                 end
        ST_HDR1: if (rx_valid) begin
                   addr_d = hdr_addr;
                   cnt_d  = rx_byte[1:0];
                   if (wr_q)                          st_d = ST_WDATA;
                   else if (hdr_addr >= AW'(MEM_BASE)) begin
                     str_start = 1'b1;
                     st_d      = ST_MSTR;
                   end else                           st_d = ST_RREG;
                 end
        ST_WDATA: if (rx_valid) begin
                    reg_we = (addr_q < AW'(MEM_BASE));
                    addr_d = addr_q + 1'b1;
                    cnt_d  = cnt_q - 1'b1;
                    if (cnt_q == 2'd0) st_d = ST_DRAIN;
                  end
        ST_RREG: if (tx_room) begin
                   reg_tx_push = 1'b1;
                   addr_d      = addr_q + 1'b1;
                   cnt_d       = cnt_q - 1'b1;
                   if (cnt_q == 2'd0) st_d = ST_DRAIN;
                 end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR0;
      addr_q <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
    end
  end

  assign reg_addr  = addr_q[REG_AW-1:0];
  assign reg_wdata = rx_byte;
  assign str_addr  = hdr_addr;
  assign str_run   = (st_q == ST_MSTR) && xact_active;

  // R13: a byte is only taken when one is offered
  p_take_needs_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> rx_valid);

  // R12: with the transaction gone, nothing is consumed
  p_no_take_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !xact_active |-> !rx_take);
endmodule

// File: rtl/swd_window_decoder.sv
module swd_window_decoder
  import swd_pkg::*;
#(
  parameter int MEM_BASE  = 'h100,
  parameter int PAGE_W    = 8,
  parameter int STA_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xact_active,
  input  logic [7:0]             rx_byte,
  input  logic                   rx_valid,
  output logic                   rx_take,
  output logic [7:0]             tx_byte,
  output logic                   tx_push,
  input  logic                   tx_room,
  output logic [ADDR_W-1:0]      mem_req_addr,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  input  logic [7:0]             mem_rsp_data,
  input  logic                   mem_rsp_valid,
  input  logic [PAGE_W-1:0]      rx_page,
  input  logic                   rx_event,
  input  logic                   tx_event,
  output logic                   irq_n,
  output logic                   reset_req,
  output logic                   rx_enable,
  output logic [8*STA_BYTES-1:0] station_addr
);
  logic reg_tx_push, reg_we, str_start, str_run, str_push;
  logic [REG_AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, str_byte;
  logic [ADDR_W-1:0] str_addr;

  swd_xact_fsm #(.AW(ADDR_W), .MEM_BASE(MEM_BASE)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .xact_active (xact_active),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .rx_take     (rx_take),
    .tx_room     (tx_room),
    .reg_tx_push (reg_tx_push),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .str_start   (str_start),
    .str_addr    (str_addr),
    .str_run     (str_run)
  );

  swd_reg_bank #(.PAGE_W(PAGE_W), .STA_BYTES(STA_BYTES), .NC(2)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (reg_we),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .rdata        (reg_rdata),
    .rx_page      (rx_page),
    .ev           ({tx_event, rx_event}),
    .irq_n        (irq_n),
    .reset_req    (reset_req),
    .rx_enable    (rx_enable),
    .station_addr (station_addr)
  );

  swd_mem_stream #(.AW(ADDR_W)) strm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (str_start),
    .start_addr    (str_addr),
    .run           (str_run),
    .mem_req_addr  (mem_req_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_valid (mem_rsp_valid),
    .tx_room       (tx_room),
    .tx_push       (str_push),
    .tx_byte       (str_byte)
  );

  assign tx_push = reg_tx_push | str_push;
  assign tx_byte = str_push ? str_byte : reg_rdata;

  // R9: no response byte is pushed without room
  p_push_needs_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_room);

  // R8: the two response sources never push together
  p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_tx_push && str_push));
endmodule

// File: tb/swd_window_decoder_tb_top.sv
`timescale 1ns/100ps
module swd_window_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xact_active = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0;
  logic rx_take;
  logic [7:0] tx_byte;
  logic tx_push;
  logic tx_room = 1'b1;
  logic [12:0] mem_req_addr;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [7:0] mem_rsp_data = '0;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] rx_page = 8'h02;
  logic rx_event = 1'b0, tx_event = 1'b0;
  logic irq_n, reset_req, rx_enable;
  logic [47:0] station_addr;

  always #2.5 clk = ~clk;

  swd_window_decoder dut_i (.*);

  int n_tests = 0, n_fail = 0;
  int tx_cnt = 0, mem_cnt = 0, rst_pulses = 0, bad_push = 0, bad_take = 0, cyc = 0;
  logic [7:0] tx_log [256];
  logic [12:0] mem_log [256];
  logic pend = 1'b0;
  logic [7:0] pend_data = '0;
  bit mem_throttle = 1'b0;

  function automatic logic [7:0] mem_val(input logic [12:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // Monitor, memory model and watchdog, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    cyc++;
    mem_req_ready = mem_throttle ? (cyc % 3 != 0) : 1'b1;
    mem_rsp_valid = pend;
    mem_rsp_data  = pend_data;
    pend = mem_req_valid && mem_req_ready;
    if (pend) begin
      pend_data = mem_val(mem_req_addr);
      if (mem_cnt < 256) mem_log[mem_cnt] = mem_req_addr;
      mem_cnt++;
    end
    if (tx_push) begin
      if (!tx_room) bad_push++;
      if (tx_cnt < 256) tx_log[tx_cnt] = tx_byte;
      tx_cnt++;
    end
    if (reset_req) rst_pulses++;
    if (rx_take && !rx_valid) bad_take++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xact_begin();
    @(negedge clk); xact_active = 1'b1;
  endtask

  task automatic xact_end();
    @(negedge clk); xact_active = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit done = 1'b0;
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1;
    while (!done) begin
      #1;
      if (rx_take) done = 1'b1;
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic send_hdr(input bit wr, input logic [12:0] a, input int len);
    send_byte({wr, a[12:6]});
    send_byte({a[5:0], 2'(len - 1)});
  endtask

  task automatic do_write(input logic [12:0] a, input int len, input logic [31:0] d);
    xact_begin();
    send_hdr(1'b1, a, len);
    for (int i = 0; i < len; i++) send_byte(d[31-8*i -: 8]);
    xact_end();
  endtask

  task automatic do_read(input logic [12:0] a, input int len, output logic [31:0] got, output int n);
    int start;
    start = tx_cnt;
    xact_begin();
    send_hdr(1'b0, a, len);
    for (int i = 0; i < len; i++) send_byte(8'hFF);
    repeat (8) @(negedge clk);
    n = tx_cnt - start;
    got = '0;
    for (int i = 0; i < len && i < n; i++) got[31-8*i -: 8] = tx_log[start+i];
    xact_end();
  endtask

  // {write, addr[12:0], count-1[1:0], bytes[31:0]}
  localparam logic [47:0] VEC [9] = '{
    {1'b0, 13'h0000, 2'd3, 32'h04020200},
    {1'b0, 13'h0031, 2'd0, 32'h17000000},
    {1'b1, 13'h0020, 2'd3, 32'hDEADBEEF},
    {1'b1, 13'h0024, 2'd1, 32'h12340000},
    {1'b0, 13'h0020, 2'd3, 32'hDEADBEEF},
    {1'b0, 13'h0024, 2'd1, 32'h12340000},
    {1'b0, 13'h0016, 2'd0, 32'h02000000},
    {1'b0, 13'h0040, 2'd0, 32'h00000000},
    {1'b0, 13'h0002, 2'd1, 32'h02000000}
  };
  localparam string VTAG [9] = '{"R3", "R4", "R5", "R5", "R5", "R5", "R7", "R3", "R2"};

  initial begin
    logic [31:0] got;
    int n, start;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(irq_n && !reset_req && !rx_enable && station_addr == '0 && !tx_push && !mem_req_valid,
        "R1", {irq_n, reset_req, rx_enable, tx_push, mem_req_valid}, 5'b10000);

    // Table walk: register reads and writes (R2, R3, R4, R5, R7)
    for (int v = 0; v < 9; v++) begin
      logic [47:0] e;
      int len;
      e = VEC[v];
      len = int'(e[33:32]) + 1;
      if (e[47]) do_write(e[46:34], len, e[31:0]);
      else begin
        do_read(e[46:34], len, got, n);
        chk(n == len && got == e[31:0], VTAG[v], {32'(n), got}, {32'(len), e[31:0]});
      end
    end
    chk(station_addr == 48'h3412EFBEADDE, "R5", station_addr, 48'h3412EFBEADDE);

    // R6: reset pulse and receive enable
    start = rst_pulses;
    do_write(13'h0000, 1, 32'h09000000);
    chk(rst_pulses - start == 1 && rx_enable, "R6", {32'(rst_pulses - start), 31'd0, rx_enable}, {32'd1, 32'd1});
    do_write(13'h0000, 1, 32'h00000000);
    chk(rst_pulses - start == 1 && !rx_enable, "R6", {32'(rst_pulses - start), 31'd0, rx_enable}, {32'd1, 32'd0});

    // R10: extra write bytes are discarded
    xact_begin();
    send_hdr(1'b1, 13'h0021, 1);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77);
    xact_end();
    do_read(13'h0020, 4, got, n);
    chk(got == 32'hDE55BEEF, "R10", got, 32'hDE55BEEF);

    // R12: abort mid-write, then decode a fresh transaction
    xact_begin();
    send_hdr(1'b1, 13'h0023, 4);
    send_byte(8'h99);
    xact_end();
    do_read(13'h0023, 2, got, n);
    chk(n == 2 && got == 32'h99120000, "R12", got, 32'h99120000);
    chk(station_addr == 48'h341299BE55DE, "R13", station_addr, 48'h341299BE55DE);

    // R11: interrupt causes and mask
    do_write(13'h0008, 1, 32'h01000000);
    @(negedge clk); rx_event = 1'b1; @(negedge clk); rx_event = 1'b0; #1;
    chk(!irq_n, "R11", irq_n, 1'b0);
    @(negedge clk); tx_event = 1'b1; @(negedge clk); tx_event = 1'b0;
    do_read(13'h0009, 1, got, n);
    chk(got[31:24] == 8'h03, "R11", got[31:24], 8'h03);
    do_write(13'h0009, 1, 32'h01000000);
    #1;
    chk(irq_n, "R11", irq_n, 1'b1);
    do_write(13'h0008, 1, 32'h03000000);
    #1;
    chk(!irq_n, "R11", irq_n, 1'b0);
    do_write(13'h0009, 1, 32'h02000000);
    #1;
    chk(irq_n, "R11", irq_n, 1'b1);

    // R9: back-pressure holds register bytes until room returns
    @(negedge clk); tx_room = 1'b0;
    start = tx_cnt;
    xact_begin();
    send_hdr(1'b0, 13'h0000, 4);
    repeat (10) @(negedge clk);
    chk(tx_cnt == start, "R9", tx_cnt - start, 0);
    tx_room = 1'b1;
    repeat (8) @(negedge clk);
    got = {tx_log[start], tx_log[start+1], tx_log[start+2], tx_log[start+3]};
    chk(tx_cnt - start == 4 && got == 32'h04020200, "R9", {32'(tx_cnt - start), got}, {32'd4, 32'h04020200});
    xact_end();

    // R8: memory stream at a split address, with throttling
    start = tx_cnt;
    mem_cnt = 0;
    mem_throttle = 1'b1;
    xact_begin();
    send_hdr(1'b0, 13'h0ABC, 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); tx_room = (i % 4 != 3);
    end
    @(negedge clk); tx_room = 1'b1;
    xact_end();
    n = tx_cnt - start;
    chk(n >= 4 && mem_cnt >= n, "R8", {32'(n), 32'(mem_cnt)}, {32'd4, 32'd4});
    begin
      bit ok = 1'b1;
      for (int k = 0; k < n && k < 256; k++)
        if (tx_log[start+k] !== mem_val(13'h0ABC + 13'(k))) ok = 1'b0;
      for (int k = 0; k < mem_cnt && k < 256; k++)
        if (mem_log[k] !== 13'h0ABC + 13'(k)) ok = 1'b0;
      chk(ok, "R8", tx_log[start], mem_val(13'h0ABC));
    end
    mem_throttle = 1'b0;
    start = tx_cnt;
    repeat (10) @(negedge clk);
    chk(tx_cnt == start && !mem_req_valid, "R8", tx_cnt - start, 0);
    do_read(13'h0031, 1, got, n);
    chk(n == 1 && got[31:24] == 8'h17, "R12", got[31:24], 8'h17);

    // R9 / R13: port protocol counters
    chk(bad_push == 0, "R9", bad_push, 0);
    chk(bad_take == 0, "R13", bad_take, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule